// File: doc/BRIEF.md
# Two-Wire Register Slave with Saturating Pointer

This block is the serial control port of a multi-port power controller. It listens on a two-wire bus with SCL and SDA, where SDA comes in on one pin and the slave's open-drain drive goes out on another. A system clock much faster than SCL samples both bus lines. The block recognises its own 7-bit device address. The three upper bits of that address are fixed, and the four lower bits come from strap pins that are latched while reset is held.

After its address, a write transaction carries a command byte, which becomes the register pointer. Any following data bytes are written to the register file through a write port with address, data and a one-cycle strobe. A read transaction fetches bytes through a combinational read port, starting from the stored pointer.

After each byte the pointer advances. It stops at a fixed top address and does not wrap. The pointer persists between transactions, so a write that carries only a command sets up later reads.

Top module: `pse_twowire_slave`

## Requirements
- R1: The slave answers the address {3'b010, latched pins}, sent MSB first and followed by the R/W bit (1 = read). It acknowledges by pulling `sda_o` low for the ninth SCL clock. `sda_o` only changes while the synchronised SCL is low.
- R2: `addr_pins` is sampled on every clock while `rst_n` is low. The value present when reset is released is kept, and later pin changes have no effect.
- R3: On an address that does not match, the slave leaves SDA released for the ack clock and for every later clock until the next START. No write strobe occurs in that time.
- R4: In a write, the byte after the address is acknowledged and held as a pending pointer. If no data byte follows, the pending value becomes the pointer when the next STOP or START is seen.
- R5: Each data byte of a write is acknowledged and produces exactly one single-cycle `wr_en` pulse. The first pulse uses the command byte as `wr_addr`, and later pulses use the advanced pointer.
- R6: After each byte written or read, the pointer moves up by one while it is below 0x26 (parameter `TOP_PTR`). At 0x26 or above, it keeps its value.
- R7: A read transaction starts at the stored pointer, which is visible on `rd_addr`. The slave shifts out `rd_data` MSB first, one bit for each SCL clock.
- R8: In a read, a master ack (SDA low in the ninth clock) makes the slave send the next byte. A master NACK ends the read, and the slave then keeps SDA released until START or STOP.
- R9: A repeated START is handled like a START. It restarts address decoding and commits a pending command byte, so a write of a command followed by a repeated START and a read returns data from that command address.
- R10: During and right after reset, `sda_o` is 1, `wr_en` is 0 and `rd_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; its release latches `addr_pins` |
| addr_pins | input | 4 | Strap pins giving the low address bits |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Open-drain drive: 0 pulls SDA low, 1 releases |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | 8 | Current pointer, used as register read address |
| rd_data | input | 8 | Register contents at `rd_addr` |

## Verification
The bench pushes command bytes near the top address. A design that wraps the pointer, or that stops one step early, writes or returns bytes at the wrong register. It also checks that a bare command byte steers a later read and a read after a repeated START; a design that applies the pointer only at STOP reads from a stale address after a repeated START.

The bench changes the strap pins after reset and sends a foreign address. A design that decodes live pins, or that keeps responding after a mismatch, acknowledges or writes there. A master NACK mid-read checks that the slave lets go of SDA; a design that keeps shifting holds the line low and blocks the STOP.

// File: rtl/pse_twowire_slave.sv
module pse_twowire_slave #(
  parameter logic [7:0] TOP_PTR = 8'h26,
  parameter logic [2:0] ADDR_HI = 3'b010,
  parameter int         SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr_pins,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDAT, S_ACK, S_RDAT, S_MACK} st_t;

  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q, mnack, cmd_pending;
  logic [3:0] hw_addr, bitcnt;
  logic [7:0] shreg, txd, ptr, cmd_hold;
  st_t st, nxt;

  wire scl_s = scl_sr[SYNC-1];
  wire sda_s = sda_sr[SYNC-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] cur = cmd_pending ? cmd_hold : ptr;

  assign rd_addr = ptr;

  function automatic logic [7:0] sat(input logic [7:0] x);
    return (x >= TOP_PTR) ? x : x + 8'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sr <= '1; sda_sr <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
      hw_addr <= addr_pins;
      st <= S_IDLE; nxt <= S_IDLE; bitcnt <= '0; shreg <= '0; txd <= '0;
      ptr <= '0; cmd_hold <= '0; cmd_pending <= 1'b0; mnack <= 1'b1;
      sda_o <= 1'b1; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      wr_en <= 1'b0;
      if (start || stop) begin
        st <= start ? S_ADDR : S_IDLE;
        bitcnt <= '0;
        sda_o <= 1'b1;
        if (cmd_pending) begin
          ptr <= cmd_hold;
          cmd_pending <= 1'b0;
        end
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == S_ADDR) begin
                if (shreg[7:1] == {ADDR_HI, hw_addr}) begin
                  sda_o <= 1'b0;
                  st <= S_ACK;
                  nxt <= shreg[0] ? S_RDAT : S_CMD;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_CMD) begin
                cmd_hold <= shreg;
                cmd_pending <= 1'b1;
                sda_o <= 1'b0;
                st <= S_ACK;
                nxt <= S_WDAT;
              end else begin
                wr_en <= 1'b1;
                wr_addr <= cur;
                wr_data <= shreg;
                ptr <= sat(cur);
                cmd_pending <= 1'b0;
                sda_o <= 1'b0;
                st <= S_ACK;
                nxt <= S_WDAT;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (nxt == S_RDAT) begin
              txd <= rd_data;
              sda_o <= rd_data[7];
              ptr <= sat(ptr);
            end else begin
              sda_o <= 1'b1;
            end
            st <= nxt;
          end
          S_RDAT: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_o <= 1'b1;
              bitcnt <= '0;
              st <= S_MACK;
            end else begin
              txd <= {txd[6:0], 1'b0};
              sda_o <= txd[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              if (!mnack) begin
                txd <= rd_data;
                sda_o <= rd_data[7];
                ptr <= sat(ptr);
                st <= S_RDAT;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_o) |-> !scl_s);
  a_r3_drive_only_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_o |-> (st == S_ACK || st == S_RDAT));
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r6_top_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == TOP_PTR && !cmd_pending) |=> ptr == TOP_PTR);
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> sda_o);

endmodule

// File: tb/pse_twowire_slave_test.sv
module pse_twowire_slave_test;
  localparam int CLK_NS = 10;
  localparam int Q = 8;
  localparam logic [7:0] TOP = 8'h26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr_pins = 4'b1010;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_o, wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int total = 0, bad = 0, wr_count = 0;
  logic [7:0] ptr_m = 8'h00;
  bit done = 0;

  wire line = sda_m & sda_o;
  localparam logic [6:0] DEV = 7'b0101010;
  localparam logic [6:0] FOREIGN = 7'b0100101;

  always #(CLK_NS/2) clk = ~clk;

  pse_twowire_slave uut (
    .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .scl_i(scl), .sda_i(line),
    .sda_o(sda_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  assign rd_data = mem[rd_addr[5:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (wr_en) begin
      mem[wr_addr[5:0]] <= wr_data;
      wr_count <= wr_count + 1;
    end
  end

  function automatic logic [7:0] sat(input logic [7:0] x);
    return (x >= TOP) ? x : x + 8'd1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic b, output logic s);
    waitq(Q/2); sda_m = b; waitq(Q/2);
    scl = 1'b1; waitq(Q/2); s = line; waitq(Q/2);
    scl = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q); scl = 1'b0;
  endtask

  task automatic bus_stop;
    waitq(Q/2); sda_m = 1'b0; waitq(Q/2); scl = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) tick(b[i], s);
    tick(1'b1, ack);
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin tick(1'b1, s); b[i] = s; end
    tick(mack, s);
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input int n);
    logic ack; logic [7:0] a, d;
    bus_start;
    send({DEV, 1'b0}, ack); chk("R1 addr ack", ack, 0);
    send(cmd, ack); chk("R4 cmd ack", ack, 0);
    a = cmd;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send(d, ack); chk("R5 data ack", ack, 0);
      exp_mem[a[5:0]] = d;
      a = sat(a);
    end
    bus_stop;
    ptr_m = a;
    waitq(2);
    chk("R4 pointer", rd_addr, ptr_m);
  endtask

  task automatic rd_body(input int n);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv(i == n - 1, b);
      chk("R7 read data", b, exp_mem[ptr_m[5:0]]);
      ptr_m = sat(ptr_m);
    end
    chk("R8 released after nack", sda_o, 1);
    bus_stop;
  endtask

  task automatic rd_txn(input int n);
    logic ack;
    bus_start;
    send({DEV, 1'b1}, ack); chk("R1 read addr ack", ack, 0);
    rd_body(n);
  endtask

  task automatic cmp_mem(input string req);
    for (int i = 0; i < 64; i++) chk(req, mem[i], exp_mem[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack; logic [7:0] b; int w0, w1;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i * 7 + 3);
    waitq(5);
    chk("R10 sda released in reset", sda_o, 1);
    rst_n = 1'b1;
    waitq(1);
    addr_pins = 4'b0101;
    waitq(4);
    chk("R10 sda released", sda_o, 1);
    chk("R10 no strobe", wr_en, 0);
    chk("R10 pointer zero", rd_addr, 0);

    // R3 and R2: foreign address (matches live pins) must be ignored
    w0 = wr_count;
    bus_start;
    send({FOREIGN, 1'b0}, ack); chk("R2 R3 foreign nack", ack, 1);
    send(8'h03, ack); chk("R3 cmd ignored", ack, 1);
    send(8'h5A, ack); chk("R3 data ignored", ack, 1);
    bus_stop;
    chk("R3 no write", wr_count, w0);
    chk("R3 pointer untouched", rd_addr, 0);
    bus_start;
    send({FOREIGN, 1'b1}, ack); chk("R3 foreign read nack", ack, 1);
    recv(1'b1, b); chk("R3 bus left high", b, 8'hFF);
    bus_stop;

    // R1 R5: basic write, strobe count
    w0 = wr_count;
    wr_txn(8'h04, 3);
    w1 = wr_count;
    chk("R5 one strobe per byte", w1 - w0, 3);
    cmp_mem("R5 mem after write");

    // R6: saturation on write
    wr_txn(8'h24, 4);
    chk("R6 top byte", mem[8'h26], exp_mem[8'h26]);
    chk("R6 no wrap", mem[8'h27], exp_mem[8'h27]);
    chk("R6 pointer held", rd_addr, 8'h26);

    // R4 command-only then R7 read, saturating
    wr_txn(8'h25, 0);
    rd_txn(3);
    chk("R6 read pointer held", rd_addr, 8'h26);

    // R9 repeated start: write command, Sr, read
    bus_start;
    send({DEV, 1'b0}, ack); chk("R9 addr ack", ack, 0);
    send(8'h05, ack); chk("R9 cmd ack", ack, 0);
    bus_start;
    send({DEV, 1'b1}, ack); chk("R9 read after sr ack", ack, 0);
    ptr_m = 8'h05;
    rd_body(2);

    // R8: early nack on single byte, then reads continue from next
    rd_txn(1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind = int'($urandom_range(0, 2));
      logic [7:0] c = 8'($urandom_range(0, 47));
      if (kind == 0) wr_txn(c, int'($urandom_range(1, 4)));
      else if (kind == 1) wr_txn(c, 0);
      else rd_txn(int'($urandom_range(1, 4)));
    end
    cmp_mem("R5 R6 mem after random");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule